// File: doc/BRIEF.md
# Deficiency-Based Unsigned Multiplier

This block multiplies two unsigned N-bit operands without multiplying them directly. Each operand is first turned into its deficiency, the distance from the operand up to the base 2^N. An inner multiplier forms the product of the two deficiencies. The low N bits of that product are the low half of the result. The bits above them are a carry that feeds the high half.

The high half comes from the base minus the sum of the deficiencies, plus that carry. It rests on the identity A·B = (A + B − 2^N)·2^N + D1·D2. The operand MSBs select one of three ways to form the high half: both operands in the upper half of the range, both in the lower half, or one in each. The selected mode is also driven out as a debug port.

The block is purely combinational and carries no clock or reset. It drops into any datapath that has N-bit unsigned operands, and N is a parameter.

Top module: `dfm_mult`

## Requirements
- R1: For every input pair, p_o equals the full unsigned product a_i·b_i in 2N bits.
- R2: p_o[N-1:0] equals the low N bits of (2^N − a_i)·(2^N − b_i).
- R3: p_o[2N-1:N] equals floor(a_i·b_i / 2^N), and the internal high-half sum never needs more than N bits.
- R4: mode_o is 2'd1 when a_i[N-1] and b_i[N-1] are both 1.
- R5: mode_o is 2'd2 when a_i[N-1] and b_i[N-1] are both 0.
- R6: mode_o is 2'd3 when a_i[N-1] and b_i[N-1] differ. The value 2'd0 never appears.
- R7: An operand of zero produces a deficiency of exactly 2^N, which needs N+1 bits, and gives p_o = 0.
- R8: When both operands are 2^N − 1, p_o equals 2^(2N) − 2^(N+1) + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| p_o | output | 2N | Unsigned product |
| mode_o | output | 2 | High-half combining mode (1 both high, 2 both low, 3 mixed) |

## Verification
The block holds no state, so a wrong deficiency, carry or mode choice appears at p_o and mode_o for the very input pair that causes it, and disappears when the inputs change. The effects of each kind of fault differ:
- A deficiency that is too narrow corrupts only the pairs that contain a zero.
- A wrong high-half form for one mode corrupts only the pairs of that MSB class.
- A dropped carry bit corrupts the high half of p_o while leaving the low half intact.

The bench therefore checks both halves and the mode separately on every clock. It covers all pairs at widths 4 and 8, and uses corner and random pairs at widths 16 and 32.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
  typedef enum logic [1:0] {
    MODE_NONE    = 2'd0,
    MODE_BOTH_HI = 2'd1,
    MODE_BOTH_LO = 2'd2,
    MODE_MIXED   = 2'd3
  } dfm_mode_e;
endpackage

// File: rtl/dfm_deficiency.sv
module dfm_deficiency #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] op_i,
  output logic [N:0]   def_o
);
  localparam logic [N:0] BASE = {1'b1, {N{1'b0}}};

  // two's complement widened by one bit so op=0 maps to 2^N
  assign def_o = BASE - {1'b0, op_i};

  always_comb begin
    // R7
    zero_def_chk: assert (def_o[N] == (op_i == '0))
      else $error("deficiency MSB mismatch for op %0h", op_i);
  end
endmodule

// File: rtl/dfm_mode_sel.sv
module dfm_mode_sel
  import dfm_pkg::*;
(
  input  logic      msb_a_i,
  input  logic      msb_b_i,
  output dfm_mode_e mode_o
);
  always_comb begin
    unique case ({msb_a_i, msb_b_i})
      2'b11:   mode_o = MODE_BOTH_HI;
      2'b00:   mode_o = MODE_BOTH_LO;
      default: mode_o = MODE_MIXED;
    endcase
  end
endmodule

// File: rtl/dfm_inner_mult.sv
module dfm_inner_mult #(
  parameter int unsigned N = 8
) (
  input  logic [N:0]     d1_i,
  input  logic [N:0]     d2_i,
  output logic [2*N+1:0] prod_o
);
  localparam int unsigned PW = 2 * N + 2;

  assign prod_o = PW'(d1_i) * PW'(d2_i);
endmodule

// File: rtl/dfm_upper.sv
module dfm_upper
  import dfm_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  dfm_mode_e    mode_i,
  input  logic [N:0]   d1_i,
  input  logic [N:0]   d2_i,
  input  logic [N+1:0] carry_i,
  output logic [N-1:0] hi_o
);
  localparam int unsigned W = N + 2;
  localparam logic [W-1:0] BASE_W = W'(1) << N;

  logic [W-1:0] def_sum;
  logic [W-1:0] hi_full;

  assign def_sum = W'(d1_i) + W'(d2_i);

  always_comb begin
    unique case (mode_i)
      // deficiencies small: base stays above their sum
      MODE_BOTH_HI: hi_full = (BASE_W - def_sum) + carry_i;
      // deficiencies large: the excess over the base is taken from the carry
      MODE_BOTH_LO: hi_full = carry_i - (def_sum - BASE_W);
      default: begin
        if (def_sum > BASE_W) hi_full = carry_i - (def_sum - BASE_W);
        else                  hi_full = (BASE_W - def_sum) + carry_i;
      end
    endcase
  end

  assign hi_o = hi_full[N-1:0];

  always_comb begin
    // R4
    hi_sum_fits_chk: assert (!(mode_i == MODE_BOTH_HI) || def_sum <= BASE_W)
      else $error("both-high mode with deficiency sum above base");
    // R5
    lo_sum_excess_chk: assert (!(mode_i == MODE_BOTH_LO) || def_sum > BASE_W)
      else $error("both-low mode with deficiency sum not above base");
    // R3
    no_overflow_chk: assert (hi_full[W-1:N] == '0)
      else $error("high half exceeds N bits");
  end
endmodule

// File: rtl/dfm_mult.sv
module dfm_mult
  import dfm_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o,
  output logic [1:0]     mode_o
);
  localparam int unsigned PW = 2 * N;

  logic [N:0]     d1, d2;
  logic [2*N+1:0] dprod;
  logic [N-1:0]   hi;
  dfm_mode_e      mode;

  dfm_deficiency #(.N(N)) i_def_a (.op_i(a_i), .def_o(d1));
  dfm_deficiency #(.N(N)) i_def_b (.op_i(b_i), .def_o(d2));

  dfm_mode_sel i_mode_sel (
    .msb_a_i (a_i[N-1]),
    .msb_b_i (b_i[N-1]),
    .mode_o  (mode)
  );

  dfm_inner_mult #(.N(N)) i_inner (
    .d1_i   (d1),
    .d2_i   (d2),
    .prod_o (dprod)
  );

  dfm_upper #(.N(N)) i_upper (
    .mode_i  (mode),
    .d1_i    (d1),
    .d2_i    (d2),
    .carry_i (dprod[2*N+1:N]),
    .hi_o    (hi)
  );

  assign p_o    = {hi, dprod[N-1:0]};
  assign mode_o = mode;

  always_comb begin
    // R1
    prod_match_chk: assert (p_o == PW'(a_i) * PW'(b_i))
      else $error("product mismatch");
    // R7
    zero_prod_chk: assert (!(a_i == '0 || b_i == '0) || p_o == '0)
      else $error("zero operand gave nonzero product");
    // R6
    mode_mixed_chk: assert ((a_i[N-1] == b_i[N-1]) || mode_o == 2'd3)
      else $error("mixed operands not in mixed mode");
    // R6
    mode_valid_chk: assert (mode_o != 2'd0)
      else $error("unused mode code");
  end
endmodule

// File: tb/test_dfm_mult.sv
module test_dfm_mult;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [3:0]  a4, b4;   logic [7:0]  p4;  logic [1:0] m4;
  logic [7:0]  a8, b8;   logic [15:0] p8;  logic [1:0] m8;
  logic [15:0] a16, b16; logic [31:0] p16; logic [1:0] m16;
  logic [31:0] a32, b32; logic [63:0] p32; logic [1:0] m32;

  dfm_mult #(.N(4))  i_dfm_mult_n4  (.a_i(a4),  .b_i(b4),  .p_o(p4),  .mode_o(m4));
  dfm_mult #(.N(8))  i_dfm_mult     (.a_i(a8),  .b_i(b8),  .p_o(p8),  .mode_o(m8));
  dfm_mult #(.N(16)) i_dfm_mult_n16 (.a_i(a16), .b_i(b16), .p_o(p16), .mode_o(m16));
  dfm_mult #(.N(32)) i_dfm_mult_n32 (.a_i(a32), .b_i(b32), .p_o(p32), .mode_o(m32));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference for one width
  task automatic check_one(input int n, input logic [63:0] a, input logic [63:0] b,
                           input logic [63:0] p, input logic [1:0] m);
    logic [63:0] mask, full, exp_lo, exp_hi, dprod;
    logic [1:0]  exp_m;
    string       tag;
    bit          ma, mb;
    mask   = (64'd1 << n) - 64'd1;
    full   = a * b;
    dprod  = ((64'd1 << n) - a) * ((64'd1 << n) - b);
    exp_lo = dprod & mask;
    exp_hi = full >> n;
    if (a == 0 || b == 0)             tag = "R7";
    else if (a == mask && b == mask)  tag = "R8";
    else                              tag = "R1";
    chk(p == full, $sformatf("%s n=%0d a=%0h b=%0h", tag, n, a, b), p, full);
    chk((p & mask) == exp_lo, $sformatf("R2 n=%0d", n), p & mask, exp_lo);
    chk((p >> n) == exp_hi, $sformatf("R3 n=%0d", n), p >> n, exp_hi);
    ma = a[n-1];
    mb = b[n-1];
    if (ma && mb) begin
      exp_m = 2'd1; tag = "R4";
    end else if (!ma && !mb) begin
      exp_m = 2'd2; tag = "R5";
    end else begin
      exp_m = 2'd3; tag = "R6";
    end
    chk(m == exp_m, $sformatf("%s mode n=%0d", tag, n), 64'(m), 64'(exp_m));
  endtask

  function automatic logic [63:0] corner(input int n, input int idx);
    logic [63:0] half;
    half = 64'd1 << (n - 1);
    case (idx)
      0:       return 64'd0;
      1:       return 64'd1;
      2:       return half;
      3:       return (64'd1 << n) - 64'd1;
      default: return half - 64'd1;
    endcase
  endfunction

  task automatic check_all();
    check_one(4,  64'(a4),  64'(b4),  64'(p4),  m4);
    check_one(8,  64'(a8),  64'(b8),  64'(p8),  m8);
    check_one(16, 64'(a16), 64'(b16), 64'(p16), m16);
    check_one(32, 64'(a32), 64'(b32), p32,      m32);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    a16 = '0; b16 = '0; a32 = '0; b32 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero inputs give zero product (R7)
    check_all();
    rst_ni = 1'b1;
    for (int k = 0; k < 65536; k++) begin
      @(posedge clk);
      a8 = k[15:8];
      b8 = k[7:0];
      a4 = k[7:4];
      b4 = k[3:0];
      if (k < 25) begin
        a16 = 16'(corner(16, k / 5));
        b16 = 16'(corner(16, k % 5));
        a32 = 32'(corner(32, k / 5));
        b32 = 32'(corner(32, k % 5));
      end else begin
        a16 = 16'($urandom);
        b16 = 16'($urandom);
        a32 = $urandom;
        b32 = $urandom;
      end
      @(negedge clk);
      check_all();
    end
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule